// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block gives a host three 8-bit parallel ports, A, B and C, on a small synchronous register bus. Port C has two 4-bit halves, and each half has its own direction. For each port the block drives an output value and a per-bit output-enable for tristate pads, and it takes the pad values back in on an input bus.

The host writes a command byte to the control address. When bit 7 of that byte is 1, the byte is a mode word: it sets the direction of each group and is stored. When bit 7 is 0, the byte sets or clears one bit of port C and leaves the stored mode alone. Only simple I/O is implemented. The handshake mode fields are kept in the register and read back, but the ports still act as plain input or output ports.

All bus transfers are sampled on the rising clock edge. The select is active low. Read data comes out of a register one cycle after the read strobe.

Top module: `ppc_top`

## Requirements
- R1: When cs_n is 0, addr selects the target: 2'b00 port A, 2'b01 port B, 2'b10 port C, 2'b11 the control register. A write with wr_en=1 to a port address loads that port's output latch at the clock edge, and pX_out shows the new value after that edge.
- R2: When cs_n is 1, writes and reads have no effect. No latch, direction or rdata changes.
- R3: Synchronous active-high reset makes every port an input (all oe bits 0). It clears all output latches and rdata to 0, and sets the control register to 8'h9B, which is the all-input simple-mode word.
- R4: In a mode word (bit 7 = 1), each of these bits gives a direction, with 1 meaning input and 0 meaning output: bit 4 for port A, bit 1 for port B, bit 3 for the C upper half and bit 0 for the C lower half. An output group drives all of its oe bits to 1, and an input group drives them to 0.
- R5: Writing a mode word clears the output latches of all three ports to zero.
- R6: A control byte with bit 7 = 0 writes the value in bit 0 to the port C bit that bits 3:1 select. No other port C bit changes, and the stored mode word is not changed.
- R7: A read (rd_en=1) of a port gives the latch value for output groups. For input groups it gives the pad value sampled at the same clock edge. Port C is resolved separately for each half.
- R8: A read of the control address returns the last mode word, including the group mode fields (bits 6:5 and bit 2). Any non-zero mode field is still treated as simple I/O.
- R9: rdata changes only on a clock edge with an accepted read and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Port / control register select |
| rd_en | input | 1 | Read strobe, active high |
| wr_en | input | 1 | Write strobe, active high |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pad input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable per bit |
| pb_in | input | 8 | Port B pad input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable per bit |
| pc_in | input | 8 | Port C pad input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable per bit |

## Verification
A stored mode word that is wrong shows on the oe outputs in the cycle right after the control write. It also shows in the next control-address read. A wrong latch, for example a bit set/reset that hits the wrong bit or a latch left uncleared after a mode word, shows on pX_out one cycle after the write, or in a port read only when that group is an output. A mux error, such as returning the latch where the pad value is expected, shows only through rdata, one cycle after a read. For that reason the bench reads every group in both directions, with pad values that differ from the latch contents.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int PORT_W = 8;
  localparam int NIB_W  = PORT_W / 2;
  localparam int NIBS   = 6;
  localparam int SEL_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    SEL_PA   = 2'b00,
    SEL_PB   = 2'b01,
    SEL_PC   = 2'b10,
    SEL_CTRL = 2'b11
  } ppc_sel_e;

  localparam int B_CL_DIR = 0;
  localparam int B_PB_DIR = 1;
  localparam int B_CU_DIR = 3;
  localparam int B_PA_DIR = 4;
  localparam int B_KIND   = 7;

  localparam logic [PORT_W-1:0] CTRL_RESET = 8'h9B;

  typedef struct packed {
    logic pa_in;
    logic pb_in;
    logic cu_in;
    logic cl_in;
  } ppc_dir_t;
endpackage

// File: rtl/ppc_ctrl.sv
module ppc_ctrl
  import ppc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] mode_q,
  output ppc_dir_t          dir,
  output logic              mode_load,
  output logic              bsr_load,
  output logic [SEL_W-1:0]  bsr_idx,
  output logic              bsr_val
);
  assign mode_load = wr_ctrl &  wdata[B_KIND];
  assign bsr_load  = wr_ctrl & ~wdata[B_KIND];
  assign bsr_idx   = wdata[SEL_W:1];
  assign bsr_val   = wdata[0];

  always_ff @(posedge clk) begin
    if (rst)            mode_q <= CTRL_RESET;
    else if (mode_load) mode_q <= wdata;
  end

  always_comb begin
    dir.pa_in = mode_q[B_PA_DIR];
    dir.pb_in = mode_q[B_PB_DIR];
    dir.cu_in = mode_q[B_CU_DIR];
    dir.cl_in = mode_q[B_CL_DIR];
  end

  AST_BSR_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
    bsr_load |=> $stable(mode_q)); // R6
  AST_MODE_STORED: assert property (@(posedge clk) disable iff (rst)
    mode_load |=> mode_q == $past(wdata)); // R8
endmodule

// File: rtl/ppc_nib.sv
module ppc_nib
  import ppc_pkg::*;
#(
  parameter int W       = NIB_W,
  parameter int BASE    = 0,
  parameter bit HAS_BSR = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic [W-1:0]     ld_data,
  input  logic             bs_en,
  input  logic [SEL_W-1:0] bs_idx,
  input  logic             bs_val,
  output logic [W-1:0]     q
);
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      q <= '0;
    end else if (ld) begin
      q <= ld_data;
    end else if (HAS_BSR && bs_en) begin
      for (int i = 0; i < W; i++) begin
        if (bs_idx == SEL_W'(BASE + i)) q[i] <= bs_val;
      end
    end
  end

  AST_NIB_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0); // R5
endmodule

// File: rtl/ppc_rdmux.sv
module ppc_rdmux
  import ppc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [1:0]        sel,
  input  logic [PORT_W-1:0] mode_q,
  input  ppc_dir_t          dir,
  input  logic [PORT_W-1:0] lat_a,
  input  logic [PORT_W-1:0] lat_b,
  input  logic [PORT_W-1:0] lat_c,
  input  logic [PORT_W-1:0] pin_a,
  input  logic [PORT_W-1:0] pin_b,
  input  logic [PORT_W-1:0] pin_c,
  output logic [PORT_W-1:0] rdata
);
  logic [PORT_W-1:0] c_view;

  always_comb begin
    c_view[PORT_W-1:NIB_W] = dir.cu_in ? pin_c[PORT_W-1:NIB_W] : lat_c[PORT_W-1:NIB_W];
    c_view[NIB_W-1:0]      = dir.cl_in ? pin_c[NIB_W-1:0]      : lat_c[NIB_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (ppc_sel_e'(sel))
        SEL_PA:  rdata <= dir.pa_in ? pin_a : lat_a;
        SEL_PB:  rdata <= dir.pb_in ? pin_b : lat_b;
        SEL_PC:  rdata <= c_view;
        default: rdata <= mode_q;
      endcase
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R9
endmodule

// File: rtl/ppc_top.sv
module ppc_top
  import ppc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic [1:0]        addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wdata,
  output logic [PORT_W-1:0] rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  logic              wr_hit, rd_hit, wr_ctrl;
  logic [PORT_W-1:0] mode_q;
  ppc_dir_t          dir;
  logic              mode_load, bsr_load, bsr_val;
  logic [SEL_W-1:0]  bsr_idx;
  logic [NIB_W-1:0]  nib_q [NIBS];

  assign wr_hit  = ~cs_n & wr_en;
  assign rd_hit  = ~cs_n & rd_en;
  assign wr_ctrl = wr_hit && (addr == SEL_CTRL);

  ppc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wdata(wdata),
    .mode_q(mode_q), .dir(dir), .mode_load(mode_load),
    .bsr_load(bsr_load), .bsr_idx(bsr_idx), .bsr_val(bsr_val)
  );

  for (genvar g = 0; g < NIBS; g++) begin : g_nib
    localparam int  PORT = g / 2;
    localparam int  HI   = g % 2;
    localparam bit  IS_C = (PORT == 2);
    logic ld;
    assign ld = wr_hit && (addr == 2'(PORT));
    ppc_nib #(.W(NIB_W), .BASE(HI * NIB_W), .HAS_BSR(IS_C)) u_nib (
      .clk(clk), .rst(rst), .clr(mode_load), .ld(ld),
      .ld_data(wdata[HI*NIB_W +: NIB_W]),
      .bs_en(bsr_load), .bs_idx(bsr_idx), .bs_val(bsr_val),
      .q(nib_q[g])
    );
  end

  assign pa_out = {nib_q[1], nib_q[0]};
  assign pb_out = {nib_q[3], nib_q[2]};
  assign pc_out = {nib_q[5], nib_q[4]};
  assign pa_oe  = {PORT_W{~dir.pa_in}};
  assign pb_oe  = {PORT_W{~dir.pb_in}};
  assign pc_oe  = {{NIB_W{~dir.cu_in}}, {NIB_W{~dir.cl_in}}};

  ppc_rdmux u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_hit), .sel(addr),
    .mode_q(mode_q), .dir(dir),
    .lat_a(pa_out), .lat_b(pb_out), .lat_c(pc_out),
    .pin_a(pa_in), .pin_b(pb_in), .pin_c(pc_in),
    .rdata(rdata)
  );

  AST_RESET_ALL_IN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && pc_out == '0)); // R3
  AST_CS_IGNORE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
              $stable(pc_oe) && $stable(rdata))); // R2
  AST_BSR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && addr == SEL_CTRL && !wdata[B_KIND]) |=>
      $countones(pc_out ^ $past(pc_out)) <= 1); // R6
  AST_OE_GROUPED: assert property (@(posedge clk) disable iff (rst)
    ($countones(pc_oe[NIB_W-1:0]) == 0 || $countones(pc_oe[NIB_W-1:0]) == NIB_W)); // R4
endmodule

// File: tb/ppc_top_tb.sv
module ppc_top_tb_top;
  logic       clk = 0;
  logic       rst = 1;
  logic       cs_n = 1;
  logic [1:0] addr = 0;
  logic       rd_en = 0, wr_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  ppc_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string tag);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic csn = 0);
    @(negedge clk); cs_n = csn; addr = a; wdata = d; wr_en = 1;
    @(posedge clk);
    @(negedge clk); wr_en = 0; cs_n = 1;
  endtask

  task automatic bus_read(input logic [1:0] a, input logic [7:0] exp, input string tag,
                          input logic csn = 0);
    @(negedge clk); cs_n = csn; addr = a; rd_en = 1;
    @(posedge clk);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); rd_en = 0; cs_n = 1;
  endtask

  // monitor: compares read data one cycle after each accepted strobe
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) check(rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // R3 reset state
    check(pa_oe, 8'h00, "R3 pa_oe after reset");
    check(pb_oe, 8'h00, "R3 pb_oe after reset");
    check(pc_oe, 8'h00, "R3 pc_oe after reset");
    check(pa_out, 8'h00, "R3 pa_out after reset");
    check(rdata, 8'h00, "R3 rdata after reset");
    bus_read(2'b11, 8'h9B, "R3 control after reset");

    // R4 all outputs
    bus_write(2'b11, 8'h80);
    check(pa_oe, 8'hFF, "R4 pa_oe output");
    check(pb_oe, 8'hFF, "R4 pb_oe output");
    check(pc_oe, 8'hFF, "R4 pc_oe output");
    bus_read(2'b11, 8'h80, "R8 control readback");

    // R1 decode and R7 output readback
    bus_write(2'b00, 8'h5A);
    bus_write(2'b01, 8'hC3);
    bus_write(2'b10, 8'h96);
    check(pa_out, 8'h5A, "R1 port A latch");
    check(pb_out, 8'hC3, "R1 port B latch");
    check(pc_out, 8'h96, "R1 port C latch");
    pa_in = 8'h01; pb_in = 8'h02; pc_in = 8'h03;
    bus_read(2'b00, 8'h5A, "R7 read output A");
    bus_read(2'b01, 8'hC3, "R7 read output B");
    bus_read(2'b10, 8'h96, "R7 read output C");

    // R2 deselected bus
    bus_write(2'b00, 8'hFF, 1'b1);
    check(pa_out, 8'h5A, "R2 write ignored");
    bus_write(2'b11, 8'h9B, 1'b1);
    check(pa_oe, 8'hFF, "R2 control write ignored");
    bus_read(2'b11, 8'h96, "R2 read ignored", 1'b1);

    // R6 bit set/reset
    bus_write(2'b11, 8'h0B);
    check(pc_out, 8'hB6, "R6 set bit 5");
    bus_write(2'b11, 8'h08);
    check(pc_out, 8'hA6, "R6 clear bit 4");
    check(pa_out, 8'h5A, "R6 port A untouched");
    bus_read(2'b11, 8'h80, "R6 mode unchanged");

    // R5 clear + R4 mixed directions: A in, B out, C upper out, C lower in
    bus_write(2'b11, 8'h91);
    check(pa_out, 8'h00, "R5 A cleared");
    check(pb_out, 8'h00, "R5 B cleared");
    check(pc_out, 8'h00, "R5 C cleared");
    check(pa_oe, 8'h00, "R4 A input");
    check(pb_oe, 8'hFF, "R4 B output");
    check(pc_oe, 8'hF0, "R4 C split");
    bus_write(2'b10, 8'h5C);
    pa_in = 8'h3C; pc_in = 8'hE7;
    bus_read(2'b00, 8'h3C, "R7 read input A");
    bus_read(2'b10, 8'h57, "R7 read split C");
    pa_in = 8'hA5;
    bus_read(2'b00, 8'hA5, "R7 read new pin A");
    bus_read(2'b01, 8'h00, "R7 read output B");

    // R8 handshake mode fields stored, still simple I/O
    bus_write(2'b11, 8'hE4);
    bus_read(2'b11, 8'hE4, "R8 mode fields stored");
    check(pa_oe, 8'hFF, "R8 A output in stored mode 2");
    check(pc_oe, 8'hFF, "R8 C output");
    bus_write(2'b00, 8'h11);
    check(pa_out, 8'h11, "R8 A simple write");
    bus_read(2'b00, 8'h11, "R8 A simple read");

    // R9 hold
    repeat (3) @(negedge clk);
    check(rdata, 8'h11, "R9 rdata held");

    // R3 reset mid-run
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
    check(pa_oe, 8'h00, "R3 pa_oe after second reset");
    check(pa_out, 8'h00, "R3 pa_out after second reset");
    check(rdata, 8'h00, "R3 rdata after second reset");
    bus_read(2'b11, 8'h9B, "R3 control after second reset");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule